// File: doc/BRIEF.md
# Paged Data Address Generator with Override

This block turns a 16-bit logical data address into a 24-bit physical address. The two top bits of the logical address pick one of four page registers. Each register holds a 10-bit page number that names one 16 KB page. The physical address is that page number followed by the low 14 bits of the logical address. With four pages loaded, software reaches up to 64 KB without reloading any register.

A short override window lets software reach any page for a few instructions without rewriting the page registers. An override command carries a page number and a length code. For the next one to four completed instructions, every data access uses the supplied page, whatever its top two address bits are. When the last instruction of the window completes, translation goes back to the page registers by itself. A page-register write that arrives during a window is stored, but it has no effect on translation until the window has closed.

Each translation is registered. The result and its valid flag appear on the clock edge that follows the access strobe.

Top module: `page_xlate`

## Requirements
- R1: Reset clears all four page registers to zero, cancels any override window, and drives `pad_o` to 0 and `pad_vld_o` to 0.
- R2: When `acc_i` is high at a clock edge, `pad_vld_o` is high after that edge and `pad_o` = {page, `lad_i[13:0]`}. When `acc_i` is low, `pad_vld_o` is low after the edge and `pad_o` keeps its last value.
- R3: Outside an override window, the page is taken from the register indexed by `lad_i[15:14]` (0 to 3).
- R4: When `ptr_we_i` is high, `ptr_wdata_i` is written into register `ptr_sel_i` at the edge and the other three registers are unchanged. An access in the same cycle still sees the old value.
- R5: `ovr_cmd_i` opens a window from the next cycle on. Every access inside the window uses `ovr_page_i` as its page, for all four values of `lad_i[15:14]`. An access in the same cycle as the command still uses the state before that command.
- R6: `ovr_len_i` holds the window length minus one: code 0 gives 1 instruction and code 3 gives 4. Each `instr_done_i` inside the window uses up one instruction. An access in the same cycle as the final completion is still overridden. Later accesses use the page registers.
- R7: A command issued while a window is open reloads both the page and the count. A command wins over an `instr_done_i` in the same cycle.
- R8: A page-register write during a window changes the stored value but not the translation inside the window. After the window closes, the new value is used.
- R9: `instr_done_i` outside a window has no effect on translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_i | input | 1 | Data-access strobe |
| lad_i | input | 16 | Logical data address |
| ptr_we_i | input | 1 | Page-register write enable |
| ptr_sel_i | input | 2 | Page register to write |
| ptr_wdata_i | input | 10 | Page number to write |
| ovr_cmd_i | input | 1 | Override command strobe |
| ovr_page_i | input | 10 | Override page number |
| ovr_len_i | input | 2 | Window length minus one |
| instr_done_i | input | 1 | Instruction-completion strobe |
| pad_o | output | 24 | Physical address |
| pad_vld_o | output | 1 | Physical address valid, one cycle after the strobe |

## Verification
On every cycle the assertions check the following:
- the valid flag follows the strobe;
- the offset is passed through unchanged and the output holds while no access is made;
- the window loads on a command, counts down once per completion and closes after its last instruction;
- an access inside a window carries the override page.

Some behaviour involves the page registers as a whole, so only the bench's scenarios can show it:
- a write in the same cycle as an access is not seen by that access;
- a write made inside a window appears only once the window closes;
- the boundary accesses at the final completion and at a reloading command.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
   localparam int unsigned PGX_LA_W   = 16;
   localparam int unsigned PGX_SEL_W  = 2;
   localparam int unsigned PGX_PAGE_W = 10;
   localparam int unsigned PGX_WIN_W  = 2;
   localparam bit          PGX_OUT_REG = 1'b1;
endpackage

// File: rtl/pgx_ptr_bank.sv
module pgx_ptr_bank #(
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned PAGE_W = 10,
   localparam int unsigned NPTR  = 1 << SEL_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [SEL_W-1:0]             wsel,
   input  logic [PAGE_W-1:0]            wdata,
   output logic [NPTR-1:0][PAGE_W-1:0]  ptrs
);
   for (genvar g = 0; g < NPTR; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ptrs[g] <= '0;
         else if (we && (wsel == SEL_W'(g)))
            ptrs[g] <= wdata;
      end
   end
endmodule

// File: rtl/pgx_ovr_window.sv
module pgx_ovr_window #(
   parameter int unsigned PAGE_W = 10,
   parameter int unsigned WIN_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd,
   input  logic [PAGE_W-1:0] cmd_page,
   input  logic [WIN_W-1:0]  cmd_len,
   input  logic              done,
   output logic              act,
   output logic [WIN_W-1:0]  left,
   output logic [PAGE_W-1:0] page
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act  <= 1'b0;
         left <= '0;
         page <= '0;
      end else if (cmd) begin
         act  <= 1'b1;
         left <= cmd_len;
         page <= cmd_page;
      end else if (act && done) begin
         if (left == '0)
            act <= 1'b0;
         else
            left <= left - 1'b1;
      end
   end
endmodule

// File: rtl/pgx_addr_mux.sv
module pgx_addr_mux #(
   parameter int unsigned LA_W    = 16,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned PAGE_W  = 10,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned NPTR   = 1 << SEL_W,
   localparam int unsigned OFS_W  = LA_W - SEL_W,
   localparam int unsigned PA_W   = PAGE_W + OFS_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         acc,
   input  logic [LA_W-1:0]              lad,
   input  logic [NPTR-1:0][PAGE_W-1:0]  ptrs,
   input  logic                         ovr_act,
   input  logic [PAGE_W-1:0]            ovr_page,
   output logic [PA_W-1:0]              pad,
   output logic                         vld
);
   logic [SEL_W-1:0]  sel;
   logic [PAGE_W-1:0] page;
   logic [PA_W-1:0]   pad_c;

   assign sel   = lad[LA_W-1:OFS_W];
   assign page  = ovr_act ? ovr_page : ptrs[sel];
   assign pad_c = {page, lad[OFS_W-1:0]};

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pad <= '0;
            vld <= 1'b0;
         end else begin
            vld <= acc;
            if (acc)
               pad <= pad_c;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign pad = pad_c;
      assign vld = acc;
   end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
   import pgx_pkg::*;
#(
   parameter int unsigned LA_W    = PGX_LA_W,
   parameter int unsigned SEL_W   = PGX_SEL_W,
   parameter int unsigned PAGE_W  = PGX_PAGE_W,
   parameter int unsigned WIN_W   = PGX_WIN_W,
   parameter bit          OUT_REG = PGX_OUT_REG,
   localparam int unsigned NPTR   = 1 << SEL_W,
   localparam int unsigned OFS_W  = LA_W - SEL_W,
   localparam int unsigned PA_W   = PAGE_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_i,
   input  logic [LA_W-1:0]   lad_i,
   input  logic              ptr_we_i,
   input  logic [SEL_W-1:0]  ptr_sel_i,
   input  logic [PAGE_W-1:0] ptr_wdata_i,
   input  logic              ovr_cmd_i,
   input  logic [PAGE_W-1:0] ovr_page_i,
   input  logic [WIN_W-1:0]  ovr_len_i,
   input  logic              instr_done_i,
   output logic [PA_W-1:0]   pad_o,
   output logic              pad_vld_o
);
   if (LA_W <= SEL_W) begin : g_bad_la
      $error("page_xlate: LA_W must exceed SEL_W");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("page_xlate: SEL_W must be 1..4");
   end
   if (PAGE_W < 1 || WIN_W < 1) begin : g_bad_w
      $error("page_xlate: PAGE_W and WIN_W must be nonzero");
   end

   logic [NPTR-1:0][PAGE_W-1:0] ptrs;
   logic                        ovr_act;
   logic [WIN_W-1:0]            ovr_left;
   logic [PAGE_W-1:0]           ovr_pg;

   pgx_ptr_bank #(.SEL_W(SEL_W), .PAGE_W(PAGE_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ptr_we_i),
      .wsel  (ptr_sel_i),
      .wdata (ptr_wdata_i),
      .ptrs  (ptrs)
   );

   pgx_ovr_window #(.PAGE_W(PAGE_W), .WIN_W(WIN_W)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (ovr_cmd_i),
      .cmd_page (ovr_page_i),
      .cmd_len  (ovr_len_i),
      .done     (instr_done_i),
      .act      (ovr_act),
      .left     (ovr_left),
      .page     (ovr_pg)
   );

   pgx_addr_mux #(.LA_W(LA_W), .SEL_W(SEL_W), .PAGE_W(PAGE_W), .OUT_REG(OUT_REG)) u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc_i),
      .lad      (lad_i),
      .ptrs     (ptrs),
      .ovr_act  (ovr_act),
      .ovr_page (ovr_pg),
      .pad      (pad_o),
      .vld      (pad_vld_o)
   );
endmodule

// File: rtl/pgx_chk.sv
module pgx_chk #(
   parameter int unsigned LA_W   = 16,
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned PAGE_W = 10,
   parameter int unsigned WIN_W  = 2,
   localparam int unsigned OFS_W = LA_W - SEL_W,
   localparam int unsigned PA_W  = PAGE_W + OFS_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_i,
   input logic [LA_W-1:0]   lad_i,
   input logic              ovr_cmd_i,
   input logic [PAGE_W-1:0] ovr_page_i,
   input logic [WIN_W-1:0]  ovr_len_i,
   input logic              instr_done_i,
   input logic [PA_W-1:0]   pad_o,
   input logic              pad_vld_o,
   input logic              ovr_act,
   input logic [WIN_W-1:0]  ovr_left,
   input logic [PAGE_W-1:0] ovr_pg
);
   AST_VLD_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_i |=> pad_vld_o); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_i |=> (!pad_vld_o && $stable(pad_o))); // R2
   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_i |=> pad_o[OFS_W-1:0] == $past(lad_i[OFS_W-1:0])); // R2
   AST_OVR_PAGE_USED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_i && ovr_act) |=> pad_o[PA_W-1:OFS_W] == $past(ovr_pg)); // R5
   AST_CMD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_cmd_i |=> (ovr_act && ovr_left == $past(ovr_len_i) && ovr_pg == $past(ovr_page_i))); // R7
   AST_WIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_act && instr_done_i && !ovr_cmd_i && ovr_left != '0)
      |=> (ovr_act && ovr_left == WIN_W'($past(ovr_left) - 1'b1))); // R6
   AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_act && instr_done_i && !ovr_cmd_i && ovr_left == '0) |=> !ovr_act); // R6
   AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_act && !ovr_cmd_i) |=> !ovr_act); // R9
endmodule

bind page_xlate pgx_chk #(
   .LA_W(LA_W), .SEL_W(SEL_W), .PAGE_W(PAGE_W), .WIN_W(WIN_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_i        (acc_i),
   .lad_i        (lad_i),
   .ovr_cmd_i    (ovr_cmd_i),
   .ovr_page_i   (ovr_page_i),
   .ovr_len_i    (ovr_len_i),
   .instr_done_i (instr_done_i),
   .pad_o        (pad_o),
   .pad_vld_o    (pad_vld_o),
   .ovr_act      (ovr_act),
   .ovr_left     (ovr_left),
   .ovr_pg       (ovr_pg)
);

// File: tb/page_xlate_test.sv
`timescale 1ns/1ps
module page_xlate_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_i = 1'b0;
   logic [15:0] lad_i = '0;
   logic        ptr_we_i = 1'b0;
   logic [1:0]  ptr_sel_i = '0;
   logic [9:0]  ptr_wdata_i = '0;
   logic        ovr_cmd_i = 1'b0;
   logic [9:0]  ovr_page_i = '0;
   logic [1:0]  ovr_len_i = '0;
   logic        instr_done_i = 1'b0;
   logic [23:0] pad_o;
   logic        pad_vld_o;

   page_xlate uut (.*);

   always #4 clk = ~clk;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit finished = 1'b0;

   // reference state built from the requirements
   logic [9:0]  m_ptr [4];
   bit          m_act;
   logic [1:0]  m_left;
   logic [9:0]  m_pg;
   logic [23:0] m_pad;

   function automatic logic [23:0] xlate(input logic [15:0] la);
      logic [9:0] pg;
      pg = m_act ? m_pg : m_ptr[la[15:14]];
      return {pg, la[13:0]};
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 4; i++) m_ptr[i] = '0;
      m_act = 1'b0; m_left = '0; m_pg = '0; m_pad = '0;
   endtask

   task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp,
                        input logic gv, input logic ev);
      checks++;
      if (got !== exp || gv !== ev) begin
         failures++;
         $display("FAIL %s: pad=%h exp=%h vld=%b exp=%b", tag, got, exp, gv, ev);
      end
   endtask

   // drive one cycle, advance the model, sample after the edge
   task automatic step(input bit acc, input logic [15:0] la, input bit we, input logic [1:0] ws,
                       input logic [9:0] wd, input bit cmd, input logic [9:0] pg,
                       input logic [1:0] ln, input bit dn, input string tag);
      acc_i = acc; lad_i = la; ptr_we_i = we; ptr_sel_i = ws; ptr_wdata_i = wd;
      ovr_cmd_i = cmd; ovr_page_i = pg; ovr_len_i = ln; instr_done_i = dn;
      if (acc) m_pad = xlate(la);
      if (we) m_ptr[ws] = wd;
      if (cmd) begin
         m_act = 1'b1; m_left = ln; m_pg = pg;
      end else if (m_act && dn) begin
         if (m_left == 2'd0) m_act = 1'b0;
         else m_left = m_left - 2'd1;
      end
      @(posedge clk); #1;
      check(tag, pad_o, m_pad, pad_vld_o, acc);
   endtask

   task automatic rd(input logic [15:0] la, input string tag);
      step(1'b1, la, 1'b0, 2'd0, 10'd0, 1'b0, 10'd0, 2'd0, 1'b0, tag);
   endtask

   task automatic done_rd(input bit acc, input logic [15:0] la, input string tag);
      step(acc, la, 1'b0, 2'd0, 10'd0, 1'b0, 10'd0, 2'd0, 1'b1, tag);
   endtask

   task automatic wr(input logic [1:0] s, input logic [9:0] d, input string tag);
      step(1'b0, 16'h0, 1'b1, s, d, 1'b0, 10'd0, 2'd0, 1'b0, tag);
   endtask

   task automatic cmd(input logic [9:0] pg, input logic [1:0] ln, input string tag);
      step(1'b0, 16'h0, 1'b0, 2'd0, 10'd0, 1'b1, pg, ln, 1'b0, tag);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         finished = 1'b1;
         failures++;
         $display("FAIL watchdog: cycles=%0d exp=<100000", cycles);
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h0051_ED11));
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      // R1: reset state, then all registers read as page 0
      check("R1 reset outputs", pad_o, 24'h0, pad_vld_o, 1'b0);
      rd(16'h0123, "R1 ptr0 zero");
      rd(16'hC456, "R1 ptr3 zero");
      step(1'b0, 16'hFFFF, 1'b0, 2'd0, 10'd0, 1'b0, 10'd0, 2'd0, 1'b0, "R2 hold when idle");

      // R3/R4: load pointers, read through each selector
      wr(2'd0, 10'h011, "R4 write p0");
      wr(2'd1, 10'h122, "R4 write p1");
      wr(2'd2, 10'h233, "R4 write p2");
      wr(2'd3, 10'h3FF, "R4 write p3");
      rd(16'h0ABC, "R3 sel0");
      rd(16'h4ABC, "R3 sel1");
      rd(16'h8001, "R3 sel2");
      rd(16'hFFFF, "R3 sel3 top address");
      // R4: write and access the same register in the same cycle
      step(1'b1, 16'h4010, 1'b1, 2'd1, 10'h2AA, 1'b0, 10'd0, 2'd0, 1'b0, "R4 same-cycle old value");
      rd(16'h4010, "R4 new value");
      rd(16'h0010, "R4 others untouched");

      // R5: command with access in the same cycle uses the old state
      step(1'b1, 16'h8020, 1'b0, 2'd0, 10'd0, 1'b1, 10'h155, 2'd2, 1'b0, "R5 cmd-cycle access");
      rd(16'h0030, "R5 override sel0");
      rd(16'hC030, "R5 override sel3");
      // R6: length code 2 -> three instructions
      done_rd(1'b1, 16'h4040, "R6 instr1");
      done_rd(1'b1, 16'h8040, "R6 instr2");
      done_rd(1'b1, 16'h0040, "R6 final completion still overridden");
      rd(16'h0040, "R6 back to pointers");

      // R6: length code 0 -> one instruction; code 3 -> four
      cmd(10'h0F0, 2'd0, "R6 open len1");
      done_rd(1'b1, 16'h1111, "R6 len1 last");
      rd(16'h1111, "R6 len1 closed");
      cmd(10'h0F1, 2'd3, "R6 open len4");
      for (int i = 0; i < 3; i++) done_rd(1'b1, 16'h2222, "R6 len4 mid");
      rd(16'h2222, "R6 len4 still open");
      done_rd(1'b0, 16'h0, "R6 len4 last");
      rd(16'h2222, "R6 len4 closed");

      // R7: reload during a window, command wins over completion
      cmd(10'h201, 2'd0, "R7 open");
      step(1'b1, 16'h3333, 1'b0, 2'd0, 10'd0, 1'b1, 10'h302, 2'd1, 1'b1, "R7 reload with done");
      rd(16'h3333, "R7 reloaded page");
      done_rd(1'b1, 16'h3333, "R7 count restarted 1");
      done_rd(1'b1, 16'h3333, "R7 count restarted 2");
      rd(16'h3333, "R7 closed after reload count");

      // R8: pointer write inside a window
      cmd(10'h0AA, 2'd1, "R8 open");
      wr(2'd2, 10'h3C3, "R8 write inside window");
      rd(16'h8555, "R8 write hidden");
      done_rd(1'b0, 16'h0, "R8 instr1");
      done_rd(1'b1, 16'h8555, "R8 last still hidden");
      rd(16'h8555, "R8 new value after window");

      // R9: completions with no window open
      done_rd(1'b0, 16'h0, "R9 done idle");
      done_rd(1'b1, 16'hC777, "R9 done idle with access");
      rd(16'h4777, "R9 pointers still used");

      // random mix covering R2, R3, R5, R6, R7
      for (int n = 0; n < 4000; n++) begin
         step($urandom_range(0, 3) != 0, 16'($urandom),
              $urandom_range(0, 5) == 0, 2'($urandom), 10'($urandom),
              $urandom_range(0, 9) == 0, 10'($urandom), 2'($urandom),
              $urandom_range(0, 2) == 0, "RND R2/R3/R5/R6");
      end

      finished = 1'b1;
      finish_run();
   end
endmodule